// File: doc/BRIEF.md
# Core Supply Reset Controller

This block drives the active-low reset of the core power domain from two independent hazard sources. The first is a pulse from a supply monitor. The second is a "regulation good" level from a brownout comparator that watches the core voltage regulator. Each source has its own enable bit, written through a small configuration write port. The block runs entirely on the slow clock. Both asynchronous hazard inputs pass through a two-flop synchroniser before any decision is made.

A supply-monitor detection resets the core at once and holds the reset for as long as the synchronised detection stays high, with a minimum of one slow cycle. A loss of regulation counts only while the regulator is enabled. It must persist for more than one slow period, that is two consecutive synchronised low samples, before it causes a reset. That reset then holds until regulation is good again.

A two-bit status register records which source caused the most recent reset. Software reads it, and the read clears it. The reset path never depends on the status bits.

The controller is a four-state machine:
- `ST_RUN`: no reset.
- `ST_SM_HOLD`: supply-monitor reset.
- `ST_BO_HOLD`: brownout reset.
- `ST_DUAL_HOLD`: both causes active.

The state code is {brownout-needed, monitor-needed}. Every cycle both needs are recomputed, and the machine moves straight to the state whose code matches them. This gives the following transitions:
- RUN→SM, RUN→BO, RUN→DUAL on new triggers.
- SM→RUN when the detection ends.
- BO→RUN when regulation returns.
- DUAL→SM or DUAL→BO when one cause clears.
- SM→DUAL or BO→DUAL when the other source fires during a hold.

Top module: `core_rst_ctrl`

## Requirements
- R1: While `por_n_i` is low, `core_rst_n_o` is low, `stat_o` is 2'b00 and both enable bits are 0. With the enables at 0, neither hazard input causes a reset.
- R2: When enable bit 0 is set, a rising `smon_det_i` that is set up before a clock edge drives `core_rst_n_o` low after the third rising edge. The reset stays low while the synchronised detection is high. When enable bit 0 is clear, the detection has no effect.
- R3: With enable bit 1 set and `vreg_en_i` high, a brownout reset occurs only after `reg_good_i` has been low for two consecutive synchronised samples. A drop that is set up before edge E1 gives a low reset after edge E4. A low pulse lasting one cycle causes no reset.
- R4: While `vreg_en_i` is low, a low `reg_good_i` causes no reset.
- R5: Once the brownout reset is asserted, it stays low while `reg_good_i` is low. It rises after the third edge following the return of `reg_good_i`.
- R6: Bit 0 of `stat_o` marks a reset caused by the supply monitor, and bit 1 marks one caused by a brownout. A new reset from one source sets its bit and clears the other bit.
- R7: If both sources start a reset in the same cycle, `stat_o` becomes 2'b11. The reset is released only when the detection has ended and regulation is good.
- R8: A one-cycle `stat_rd_i` pulse clears `stat_o` at the next edge. A set event in the same cycle takes priority over the clear.
- R9: Every reset lasts at least one full slow cycle. A one-cycle detection pulse gives a reset that is low for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow_i | input | 1 | Slow clock |
| por_n_i | input | 1 | Asynchronous power-on reset, active low |
| smon_det_i | input | 1 | Supply monitor detection, asynchronous |
| reg_good_i | input | 1 | Regulation good level, asynchronous, high = good |
| vreg_en_i | input | 1 | Regulator enabled, slow-domain level |
| cfg_we_i | input | 1 | Enable register write strobe |
| cfg_wdata_i | input | 2 | bit0 = monitor reset enable, bit1 = brownout reset enable |
| stat_rd_i | input | 1 | Status read strobe (clear on read) |
| stat_o | output | 2 | bit0 = last reset by monitor, bit1 = last reset by brownout |
| core_rst_n_o | output | 1 | Core reset, active low |

## Verification
Count the edges from an input change that is set up before edge E1:
- A detection reaches the reset output after E3, because it passes two synchroniser flops and then the registered state.
- Release after the return of regulation, or after the end of a detection, also follows after E3.
- A brownout trigger needs one more edge for its filter sample, so it appears after E4.
- The status register follows the reset state on the same edge, and a read clears it one edge after the strobe.

The bench drives inputs and samples outputs only on falling edges. It checks the output in the cycle just before each due edge, to confirm nothing happens early, and again just after that edge.

// File: rtl/core_rst_pkg.sv
package core_rst_pkg;

    // State code is {brownout needed, monitor needed}
    typedef enum logic [1:0] {
        ST_RUN       = 2'b00,
        ST_SM_HOLD   = 2'b01,
        ST_BO_HOLD   = 2'b10,
        ST_DUAL_HOLD = 2'b11
    } crc_state_e;

    localparam int CFG_W      = 2;
    localparam int CFG_SM_BIT = 0;
    localparam int CFG_BO_BIT = 1;

endpackage

// File: rtl/crc_sync.sv
module crc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/crc_bo_filter.sv
module crc_bo_filter #(
    parameter int FILT_SAMPLES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic active_i,
    input  logic good_s_i,
    output logic trig_o
);
    localparam int CW = (FILT_SAMPLES > 2) ? $clog2(FILT_SAMPLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_SAMPLES - 1);

    logic [CW-1:0] low_cnt_q;

    // Counts consecutive low samples, saturating one below the threshold
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            low_cnt_q <= '0;
        end else if (!active_i || good_s_i) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != LAST) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    // Trigger on the sample that completes the run of lows
    assign trig_o = active_i && !good_s_i && (low_cnt_q == LAST);
endmodule

// File: rtl/crc_status.sv
module crc_status (
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       sm_set_i,
    input  logic       bo_set_i,
    input  logic       rd_i,
    output logic [1:0] stat_o
);
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            stat_o <= 2'b00;
        end else if (sm_set_i || bo_set_i) begin
            stat_o <= {bo_set_i, sm_set_i};
        end else if (rd_i) begin
            stat_o <= 2'b00;
        end
    end
endmodule

// File: rtl/core_rst_ctrl.sv
module core_rst_ctrl
    import core_rst_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int FILT_SAMPLES = 2
) (
    input  logic             clk_slow_i,
    input  logic             por_n_i,
    input  logic             smon_det_i,
    input  logic             reg_good_i,
    input  logic             vreg_en_i,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    input  logic             stat_rd_i,
    output logic [1:0]       stat_o,
    output logic             core_rst_n_o
);
    logic [CFG_W-1:0] cfg_q;
    logic             det_s;
    logic             good_s;
    logic             sm_trig;
    logic             bo_trig;
    logic             sm_held;
    logic             bo_held;
    logic             sm_need;
    logic             bo_need;
    logic             sm_set;
    logic             bo_set;
    logic             rst_n_q;
    crc_state_e       state_q;
    crc_state_e       state_d;

    crc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_det_sync (
        .clk_i   (clk_slow_i),
        .rst_n_i (por_n_i),
        .d_i     (smon_det_i),
        .q_o     (det_s)
    );

    crc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_good_sync (
        .clk_i   (clk_slow_i),
        .rst_n_i (por_n_i),
        .d_i     (reg_good_i),
        .q_o     (good_s)
    );

    crc_bo_filter #(.FILT_SAMPLES(FILT_SAMPLES)) u_bo_filt (
        .clk_i    (clk_slow_i),
        .rst_n_i  (por_n_i),
        .active_i (cfg_q[CFG_BO_BIT] && vreg_en_i),
        .good_s_i (good_s),
        .trig_o   (bo_trig)
    );

    crc_status u_status (
        .clk_i    (clk_slow_i),
        .rst_n_i  (por_n_i),
        .sm_set_i (sm_set),
        .bo_set_i (bo_set),
        .rd_i     (stat_rd_i),
        .stat_o   (stat_o)
    );

    // Enable register
    always_ff @(posedge clk_slow_i or negedge por_n_i) begin
        if (!por_n_i) begin
            cfg_q <= '0;
        end else if (cfg_we_i) begin
            cfg_q <= cfg_wdata_i;
        end
    end

    assign sm_trig = cfg_q[CFG_SM_BIT] && det_s;

    // Next-state logic: recompute both needs each cycle
    always_comb begin
        sm_held = 1'b0;
        bo_held = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                sm_held = 1'b0;
            end
            ST_SM_HOLD: begin
                sm_held = 1'b1;
            end
            ST_BO_HOLD: begin
                bo_held = 1'b1;
            end
            ST_DUAL_HOLD: begin
                sm_held = 1'b1;
                bo_held = 1'b1;
            end
        endcase
        sm_need = sm_trig;
        bo_need = bo_held ? !good_s : bo_trig;
        state_d = crc_state_e'({bo_need, sm_need});
        sm_set  = sm_need && !sm_held;
        bo_set  = bo_need && !bo_held;
    end

    // State register
    always_ff @(posedge clk_slow_i or negedge por_n_i) begin
        if (!por_n_i) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: glitch-free reset, low during power-on reset
    always_ff @(posedge clk_slow_i or negedge por_n_i) begin
        if (!por_n_i) begin
            rst_n_q <= 1'b0;
        end else begin
            rst_n_q <= (state_d == ST_RUN);
        end
    end

    assign core_rst_n_o = rst_n_q;
endmodule

// File: rtl/crc_checker.sv
module crc_checker
    import core_rst_pkg::*;
(
    input logic       clk_i,
    input logic       por_n_i,
    input logic       vreg_en_i,
    input logic       stat_rd_i,
    input logic [1:0] stat_i,
    input logic       core_rst_n_i,
    input crc_state_e state_i,
    input logic       sm_trig_i,
    input logic       good_s_i,
    input logic       sm_set_i,
    input logic       bo_set_i
);
    assert_sm_entry_R2: assert property (@(posedge clk_i) disable iff (!por_n_i)
        sm_trig_i |=> !core_rst_n_i);

    assert_bo_gate_R4: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (state_i == ST_RUN && !vreg_en_i && !sm_trig_i) |=> core_rst_n_i);

    assert_bo_hold_R5: assert property (@(posedge clk_i) disable iff (!por_n_i)
        ((state_i == ST_BO_HOLD || state_i == ST_DUAL_HOLD) && !good_s_i) |=> !core_rst_n_i);

    assert_src_replace_R6: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (bo_set_i && !sm_set_i) |=> (stat_i == 2'b10));

    assert_read_clear_R8: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (stat_rd_i && !sm_set_i && !bo_set_i) |=> (stat_i == 2'b00));
endmodule

bind core_rst_ctrl crc_checker u_crc_chk (
    .clk_i        (clk_slow_i),
    .por_n_i      (por_n_i),
    .vreg_en_i    (vreg_en_i),
    .stat_rd_i    (stat_rd_i),
    .stat_i       (stat_o),
    .core_rst_n_i (core_rst_n_o),
    .state_i      (state_q),
    .sm_trig_i    (sm_trig),
    .good_s_i     (good_s),
    .sm_set_i     (sm_set),
    .bo_set_i     (bo_set)
);

// File: tb/core_rst_ctrl_tb.sv
module core_rst_ctrl_tb;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       det = 1'b0;
    logic       good = 1'b1;
    logic       vreg = 1'b1;
    logic       we = 1'b0;
    logic [1:0] wdata = 2'b00;
    logic       rd = 1'b0;
    logic [1:0] stat;
    logic       rst_n;
    int         checks = 0;
    int         errors = 0;
    bit         reported = 1'b0;

    always #2.5 clk = ~clk;

    core_rst_ctrl u_dut (
        .clk_slow_i   (clk),
        .por_n_i      (por_n),
        .smon_det_i   (det),
        .reg_good_i   (good),
        .vreg_en_i    (vreg),
        .cfg_we_i     (we),
        .cfg_wdata_i  (wdata),
        .stat_rd_i    (rd),
        .stat_o       (stat),
        .core_rst_n_o (rst_n)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
    endtask

    task automatic write_cfg(input logic [1:0] v);
        wdata = v; we = 1'b1;
        tick(1);
        we = 1'b0;
    endtask

    task automatic read_clear();
        rd = 1'b1;
        tick(1);
        rd = 1'b0;
        chk("R8 status cleared by read", stat, 0);
    endtask

    task automatic t_reset();
        tick(3);
        chk("R1 reset low during POR", rst_n, 0);
        chk("R1 status zero during POR", stat, 0);
        por_n = 1'b1;
        tick(1);
        chk("R1 reset released", rst_n, 1);
    endtask

    task automatic t_disabled();
        int bad = 0;
        det = 1'b1;
        tick(1);
        det = 1'b0;
        good = 1'b0;
        for (int i = 0; i < 6; i++) begin
            tick(1);
            if (!rst_n) bad++;
        end
        good = 1'b1;
        tick(3);
        chk("R1 no reset with enables at 0", bad, 0);
        chk("R1 status untouched", stat, 0);
    endtask

    task automatic t_sm_pulse();
        write_cfg(2'b01);
        det = 1'b1;
        tick(1);
        det = 1'b0;
        tick(1);
        chk("R2 not yet asserted after E2", rst_n, 1);
        tick(1);
        chk("R2 asserted after E3", rst_n, 0);
        tick(1);
        chk("R9 one-cycle pulse released after E4", rst_n, 1);
        chk("R6 monitor status bit", stat, 1);
        read_clear();
    endtask

    task automatic t_sm_long();
        det = 1'b1;
        tick(4);
        det = 1'b0;
        chk("R2 low while detect held", rst_n, 0);
        tick(2);
        chk("R2 still low after E6", rst_n, 0);
        tick(1);
        chk("R2 released after E7", rst_n, 1);
        read_clear();
    endtask

    task automatic t_glitch();
        int bad = 0;
        write_cfg(2'b10);
        good = 1'b0;
        tick(1);
        good = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick(1);
            if (!rst_n) bad++;
        end
        chk("R3 single-cycle low ignored", bad, 0);
        chk("R3 no status from glitch", stat, 0);
    endtask

    task automatic t_vreg_off();
        int bad = 0;
        vreg = 1'b0;
        good = 1'b0;
        for (int i = 0; i < 6; i++) begin
            tick(1);
            if (!rst_n) bad++;
        end
        good = 1'b1;
        tick(3);
        vreg = 1'b1;
        chk("R4 no brownout with regulator off", bad, 0);
        chk("R4 no status with regulator off", stat, 0);
    endtask

    task automatic t_bo_main();
        write_cfg(2'b11);
        det = 1'b1;
        tick(1);
        det = 1'b0;
        tick(4);
        chk("R6 monitor status before brownout", stat, 1);
        good = 1'b0;
        tick(3);
        chk("R3 not asserted after E3", rst_n, 1);
        tick(1);
        chk("R3 asserted after E4", rst_n, 0);
        chk("R6 brownout replaces monitor bit", stat, 2);
        tick(10);
        chk("R5 held while regulation low", rst_n, 0);
        good = 1'b1;
        tick(2);
        chk("R5 still low two edges after return", rst_n, 0);
        tick(1);
        chk("R5 released after third edge", rst_n, 1);
        read_clear();
    endtask

    task automatic t_dual_short();
        good = 1'b0;
        tick(1);
        det = 1'b1;
        tick(1);
        det = 1'b0;
        tick(1);
        chk("R7 not asserted after E3", rst_n, 1);
        tick(1);
        chk("R7 asserted after E4", rst_n, 0);
        chk("R7 both status bits", stat, 3);
        tick(3);
        chk("R7 held while regulation low", rst_n, 0);
        good = 1'b1;
        tick(2);
        chk("R7 low until regulation sampled", rst_n, 0);
        tick(1);
        chk("R7 released when both clear", rst_n, 1);
        chk("R7 status kept", stat, 3);
    endtask

    task automatic t_dual_long();
        rd = 1'b1;
        good = 1'b0;
        tick(1);
        rd = 1'b0;
        det = 1'b1;
        tick(3);
        chk("R7 dual asserted", rst_n, 0);
        chk("R8 set wins over earlier clear", stat, 3);
        good = 1'b1;
        tick(4);
        chk("R7 held by ongoing detection", rst_n, 0);
        det = 1'b0;
        tick(2);
        chk("R7 still low after E10", rst_n, 0);
        tick(1);
        chk("R7 released after E11", rst_n, 1);
        rd = 1'b1;
        det = 1'b1;
        tick(1);
        rd = 1'b0;
        det = 1'b0;
        chk("R8 read clears status", stat, 0);
        tick(2);
        chk("R6 new monitor reset sets bit 0 only", stat, 1);
        tick(2);
    endtask

    initial begin
        tick(1);
        t_reset();
        t_disabled();
        t_sm_pulse();
        t_sm_long();
        t_glitch();
        t_vreg_off();
        t_bo_main();
        t_dual_short();
        t_dual_long();
        report();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        report();
        $finish;
    end
endmodule